// File: doc/BRIEF.md
# Floating-Point Register Operand Access Unit

This block turns the 5-bit register fields of a floating-point instruction into word addresses of a 64 x 32-bit register file, and tracks which half of that file currently holds live data. Each access names up to two source operands and one destination operand. Each operand is single (one word), double (two words) or quad (four words). The unit returns the source operands, writes the destination, and keeps a small trap-type field that gates every access.

An access is offered with `req_valid` while `req_ready` is high. Before it looks at any operand, the unit compares its trap-type field with the value the operation expects. On a match it clears the field and decodes the operands. An illegal quad specifier makes the unit store the invalid-register code in the field. A read from a half of the file that is not live returns zero. The first write to a half clears all 32 words of that half in the same cycle, marks the half live, and stores the new data. If the global enable is clear, that first write also sets the enable and drops both half flags before doing so. The response comes back one cycle after acceptance.

Top module: `fpreg_access`

## Requirements
- R1: A single-size operand (size code 1) addresses the register whose index equals its 5-bit field. Word k of an operand bus is bits [32k+31:32k].
- R2: A double (code 2) or quad (code 3) operand starts at index {field[0], field[4:1], 0}. A double covers 2 consecutive words and a quad covers 4. Operand bus words beyond the operand size, and every word of an operand with code 0, read as zero.
- R3: If any quad operand has field bit 1 set, the access responds with status 2. The trap-type field becomes 6, and no register, half flag or enable changes.
- R4: If the trap-type field differs from `req_tt_exp`, the access responds with status 1. The trap-type field, the registers, the half flags and the enable all stay unchanged. This check comes before the check of R3.
- R5: An access that passes the checks of R3 and R4 responds with status 0 and clears the trap-type field to 0.
- R6: Indices 0 to 31 form the lower half and 32 to 63 the upper half. A source word read from a half whose live flag is clear returns zero.
- R7: A write made while the enable is clear sets the enable and clears both half flags before it proceeds. The other half then reads as zero until it is written.
- R8: A write to a half that is not live zeroes all 32 words of that half in the same cycle, stores the operand words and sets that half's flag.
- R9: Source data returned by an access reflects the register file before that access's own write and clear.
- R10: `tt_wr` loads `tt_wr_val` into the trap-type field in a cycle with no accepted access. In a cycle with an accepted access, it is ignored.
- R11: While reset is held, `req_ready`, `resp_valid`, the enable, both half flags and the trap-type field are 0. `req_ready` is 1 from the first cycle after reset. `resp_valid` is high exactly in the cycle after each accepted access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access offered |
| req_ready | output | 1 | Unit can accept an access |
| req_tt_exp | input | 3 | Trap type the operation expects |
| rs1_size | input | 2 | First source size: 0 none, 1 single, 2 double, 3 quad |
| rs1_field | input | 5 | First source register field |
| rs2_size | input | 2 | Second source size code |
| rs2_field | input | 5 | Second source register field |
| rd_size | input | 2 | Destination size code, 0 for no write |
| rd_field | input | 5 | Destination register field |
| wr_data | input | 128 | Destination words, word k in bits [32k+31:32k] |
| tt_wr | input | 1 | Load the trap-type field |
| tt_wr_val | input | 3 | Value for the trap-type field |
| resp_valid | output | 1 | Response valid |
| resp_status | output | 2 | 0 accepted, 1 trap-type mismatch, 2 invalid register |
| rs1_data | output | 128 | First source operand |
| rs2_data | output | 128 | Second source operand |
| trap_type | output | 3 | Trap-type field |
| fp_enable | output | 1 | Global enable flag |
| half_live | output | 2 | Live flags, bit 0 lower half, bit 1 upper half |

## Verification
Within a single access, a source read can fall in the same cycle as the parallel clear and write of the half it reads. The bench provokes this by reading the destination register while making the first write to a half that is not live, and its random phase makes the same overlap at random. The read must return the state before the access: zero for a half that was not live, or the old word otherwise. A later access must see the written words with the rest of that half at zero.

// File: rtl/fpreg_pkg.sv
package fpreg_pkg;
  typedef enum logic [1:0] {
    SZ_NONE = 2'd0,
    SZ_SGL  = 2'd1,
    SZ_DBL  = 2'd2,
    SZ_QUAD = 2'd3
  } opsz_e;

  typedef enum logic [1:0] {
    ST_OK          = 2'd0,
    ST_TT_MISMATCH = 2'd1,
    ST_BAD_REG     = 2'd2
  } status_e;

  localparam int unsigned MAX_WORDS = 4;

  // number of 32-bit words an operand of the given size occupies
  function automatic logic [2:0] size_words(input logic [1:0] sz);
    case (sz)
      2'd1:    return 3'd1;
      2'd2:    return 3'd2;
      2'd3:    return 3'd4;
      default: return 3'd0;
    endcase
  endfunction
endpackage

// File: rtl/fpreg_spec_decode.sv
module fpreg_spec_decode #(
  parameter int FIELD_W = 5,
  localparam int IDX_W = FIELD_W + 1
) (
  input  logic [1:0]         size,
  input  logic [FIELD_W-1:0] field,
  output logic [IDX_W-1:0]   idx,
  output logic               bad,
  output logic               upper
);
  import fpreg_pkg::*;

  always_comb begin
    if (size == SZ_SGL)
      idx = {1'b0, field};
    else
      idx = {field[0], field[FIELD_W-1:1], 1'b0};
    bad   = (size == SZ_QUAD) && field[1];
    upper = idx[IDX_W-1];
  end
endmodule

// File: rtl/fpreg_file.sv
module fpreg_file #(
  parameter int DATA_W = 32,
  parameter int NREG   = 64,
  parameter int WORDS  = 4,
  localparam int IDX_W = $clog2(NREG),
  localparam int SEL_W = $clog2(WORDS),
  localparam int CNT_W = SEL_W + 1,
  localparam int HALF  = NREG / 2
) (
  input  logic                    clk,
  input  logic                    clr_en,
  input  logic                    clr_upper,
  input  logic                    wr_en,
  input  logic [IDX_W-1:0]        wr_idx,
  input  logic [CNT_W-1:0]        wr_cnt,
  input  logic [WORDS*DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]        ra_idx,
  input  logic [IDX_W-1:0]        rb_idx,
  output logic [WORDS*DATA_W-1:0] ra_data,
  output logic [WORDS*DATA_W-1:0] rb_data
);
  logic [DATA_W-1:0] mem [NREG];
  logic [NREG-1:0]   hit;
  logic [DATA_W-1:0] wval [NREG];

  // per-entry write select: offset from the operand base picks the word
  always_comb begin
    for (int i = 0; i < NREG; i++) begin
      logic [IDX_W-1:0] off;
      off     = IDX_W'(i) - wr_idx;
      hit[i]  = wr_en && (off < IDX_W'(wr_cnt));
      wval[i] = wr_data[off[SEL_W-1:0]*DATA_W +: DATA_W];
    end
  end

  // operand words win over the half clear in the same cycle
  always_ff @(posedge clk) begin
    for (int i = 0; i < NREG; i++) begin
      if (hit[i])
        mem[i] <= wval[i];
      else if (clr_en && ((i >= HALF) == clr_upper))
        mem[i] <= '0;
    end
  end

  always_comb begin
    for (int k = 0; k < WORDS; k++) begin
      ra_data[k*DATA_W +: DATA_W] = mem[ra_idx + IDX_W'(k)];
      rb_data[k*DATA_W +: DATA_W] = mem[rb_idx + IDX_W'(k)];
    end
  end
endmodule

// File: rtl/fpreg_src_gate.sv
module fpreg_src_gate #(
  parameter int DATA_W = 32,
  parameter int WORDS  = 4
) (
  input  logic [1:0]              size,
  input  logic                    live,
  input  logic [WORDS*DATA_W-1:0] raw,
  output logic [WORDS*DATA_W-1:0] data
);
  import fpreg_pkg::*;

  always_comb begin
    for (int k = 0; k < WORDS; k++) begin
      if (live && (k < int'(size_words(size))))
        data[k*DATA_W +: DATA_W] = raw[k*DATA_W +: DATA_W];
      else
        data[k*DATA_W +: DATA_W] = '0;
    end
  end
endmodule

// File: rtl/fpreg_access.sv
module fpreg_access #(
  parameter int FIELD_W = 5,
  parameter int DATA_W  = 32,
  parameter int TT_W    = 3,
  parameter logic [TT_W-1:0] TT_INVREG = TT_W'(6),
  localparam int IDX_W  = FIELD_W + 1,
  localparam int NREG   = 1 << IDX_W,
  localparam int WORDS  = fpreg_pkg::MAX_WORDS,
  localparam int OPND_W = WORDS * DATA_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [TT_W-1:0]    req_tt_exp,
  input  logic [1:0]         rs1_size,
  input  logic [FIELD_W-1:0] rs1_field,
  input  logic [1:0]         rs2_size,
  input  logic [FIELD_W-1:0] rs2_field,
  input  logic [1:0]         rd_size,
  input  logic [FIELD_W-1:0] rd_field,
  input  logic [OPND_W-1:0]  wr_data,
  input  logic               tt_wr,
  input  logic [TT_W-1:0]    tt_wr_val,
  output logic               resp_valid,
  output logic [1:0]         resp_status,
  output logic [OPND_W-1:0]  rs1_data,
  output logic [OPND_W-1:0]  rs2_data,
  output logic [TT_W-1:0]    trap_type,
  output logic               fp_enable,
  output logic [1:0]         half_live
);
  import fpreg_pkg::*;

  logic [IDX_W-1:0]  s1_idx, s2_idx, d_idx;
  logic              s1_bad, s2_bad, d_bad;
  logic              s1_up, s2_up, d_up;
  logic [OPND_W-1:0] s1_raw, s2_raw, s1_val, s2_val;

  fpreg_spec_decode #(.FIELD_W(FIELD_W)) u_dec_s1 (
    .size(rs1_size), .field(rs1_field), .idx(s1_idx), .bad(s1_bad), .upper(s1_up));
  fpreg_spec_decode #(.FIELD_W(FIELD_W)) u_dec_s2 (
    .size(rs2_size), .field(rs2_field), .idx(s2_idx), .bad(s2_bad), .upper(s2_up));
  fpreg_spec_decode #(.FIELD_W(FIELD_W)) u_dec_d (
    .size(rd_size), .field(rd_field), .idx(d_idx), .bad(d_bad), .upper(d_up));

  logic       acc, tt_ok, bad_any, go, do_wr, need_clr;
  logic [1:0] live_base, live_next;

  always_comb begin
    acc       = req_valid && req_ready;
    tt_ok     = (trap_type == req_tt_exp);
    bad_any   = s1_bad || s2_bad || d_bad;
    go        = acc && tt_ok && !bad_any;
    do_wr     = go && (rd_size != SZ_NONE);
    // enable clear: both halves count as dead before the write proceeds
    live_base = fp_enable ? half_live : 2'b00;
    need_clr  = do_wr && !live_base[d_up];
    live_next = live_base;
    live_next[d_up] = 1'b1;
  end

  fpreg_file #(.DATA_W(DATA_W), .NREG(NREG), .WORDS(WORDS)) u_file (
    .clk      (clk),
    .clr_en   (need_clr),
    .clr_upper(d_up),
    .wr_en    (do_wr),
    .wr_idx   (d_idx),
    .wr_cnt   (size_words(rd_size)),
    .wr_data  (wr_data),
    .ra_idx   (s1_idx),
    .rb_idx   (s2_idx),
    .ra_data  (s1_raw),
    .rb_data  (s2_raw)
  );

  fpreg_src_gate #(.DATA_W(DATA_W), .WORDS(WORDS)) u_gate_s1 (
    .size(rs1_size), .live(half_live[s1_up]), .raw(s1_raw), .data(s1_val));
  fpreg_src_gate #(.DATA_W(DATA_W), .WORDS(WORDS)) u_gate_s2 (
    .size(rs2_size), .live(half_live[s2_up]), .raw(s2_raw), .data(s2_val));

  always_ff @(posedge clk) begin
    if (rst) begin
      req_ready   <= 1'b0;
      resp_valid  <= 1'b0;
      resp_status <= ST_OK;
      rs1_data    <= '0;
      rs2_data    <= '0;
      trap_type   <= '0;
      fp_enable   <= 1'b0;
      half_live   <= 2'b00;
    end else begin
      req_ready  <= 1'b1;
      resp_valid <= acc;
      if (acc) begin
        rs1_data <= s1_val;
        rs2_data <= s2_val;
        if (!tt_ok) begin
          resp_status <= ST_TT_MISMATCH;
        end else if (bad_any) begin
          resp_status <= ST_BAD_REG;
          trap_type   <= TT_INVREG;
        end else begin
          resp_status <= ST_OK;
          trap_type   <= '0;
        end
      end else if (tt_wr) begin
        trap_type <= tt_wr_val;
      end
      if (do_wr) begin
        fp_enable <= 1'b1;
        half_live <= live_next;
      end
    end
  end
endmodule

// File: rtl/fpreg_access_chk.sv
module fpreg_access_chk #(
  parameter int TT_W = 3,
  parameter logic [TT_W-1:0] TT_INVREG = TT_W'(6)
) (
  input logic            clk,
  input logic            rst,
  input logic            req_valid,
  input logic            req_ready,
  input logic            tt_wr,
  input logic [TT_W-1:0] tt_wr_val,
  input logic            resp_valid,
  input logic [1:0]      resp_status,
  input logic [TT_W-1:0] trap_type,
  input logic            fp_enable,
  input logic [1:0]      half_live
);
  a_r11_resp_follows: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> resp_valid);
  a_r11_resp_single: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && req_ready) |=> !resp_valid);
  a_r11_ready_up: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> req_ready);
  a_r5_tt_cleared: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && resp_status == 2'd0) |-> trap_type == '0);
  a_r3_tt_invreg: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && resp_status == 2'd2) |-> trap_type == TT_INVREG);
  a_r3_no_state_change: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && resp_status == 2'd2) |-> ($stable(half_live) && $stable(fp_enable)));
  a_r4_mismatch_frozen: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && resp_status == 2'd1)
      |-> ($stable(trap_type) && $stable(half_live) && $stable(fp_enable)));
  a_r7_live_needs_enable: assert property (@(posedge clk) disable iff (rst)
    (half_live != 2'b00) |-> fp_enable);
  a_r7_enable_sticky: assert property (@(posedge clk) disable iff (rst)
    fp_enable |=> fp_enable);
  a_r10_tt_load: assert property (@(posedge clk) disable iff (rst)
    (tt_wr && !(req_valid && req_ready)) |=> trap_type == $past(tt_wr_val));
endmodule

bind fpreg_access fpreg_access_chk #(.TT_W(TT_W), .TT_INVREG(TT_INVREG)) u_chk (.*);

// File: tb/fpreg_access_bench.sv
`timescale 1ns/1ps
module fpreg_access_bench;
  localparam int NR = 64, HALF = 32;

  logic clk = 1'b0, rst = 1'b1;
  always #2 clk = ~clk;

  logic         req_valid = 0, req_ready, tt_wr = 0, resp_valid, fp_enable;
  logic [2:0]   req_tt_exp = 0, tt_wr_val = 0, trap_type;
  logic [1:0]   rs1_size = 0, rs2_size = 0, rd_size = 0, resp_status, half_live;
  logic [4:0]   rs1_field = 0, rs2_field = 0, rd_field = 0;
  logic [127:0] wr_data = 0, rs1_data, rs2_data;

  fpreg_access u_fpreg_access (.*);

  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] m_mem [NR];
  bit          m_live [2];
  bit          m_fen;
  logic [2:0]  m_tt;

  function automatic int f_idx(input logic [1:0] sz, input logic [4:0] f);
    if (sz == 2'd1) return int'(f);
    return (int'(f[0]) << 5) | (int'(f[4:1]) << 1);
  endfunction

  function automatic int f_words(input logic [1:0] sz);
    return (sz == 0) ? 0 : (sz == 1) ? 1 : (sz == 2) ? 2 : 4;
  endfunction

  function automatic logic [127:0] f_read(input logic [1:0] sz, input logic [4:0] f);
    logic [127:0] r;
    int b, h;
    r = '0;
    b = f_idx(sz, f);
    h = b / HALF;
    for (int k = 0; k < f_words(sz); k++)
      if (m_live[h]) r[k*32 +: 32] = m_mem[(b + k) % NR];
    return r;
  endfunction

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic model_write(input logic [1:0] dz, input logic [4:0] df, input logic [127:0] wd);
    int b, h;
    b = f_idx(dz, df);
    h = b / HALF;
    if (!m_fen) begin m_fen = 1; m_live[0] = 0; m_live[1] = 0; end
    if (!m_live[h]) begin
      for (int i = 0; i < HALF; i++) m_mem[h*HALF + i] = '0;
      m_live[h] = 1;
    end
    for (int k = 0; k < f_words(dz); k++) m_mem[b + k] = wd[k*32 +: 32];
  endtask

  task automatic check_state(input string req);
    check({req, " trap_type"}, trap_type, m_tt);
    check({req, " fp_enable"}, fp_enable, m_fen);
    check({req, " half_live"}, half_live, {m_live[1], m_live[0]});
  endtask

  task automatic access(input string req, input logic [2:0] exp_tt,
                        input logic [1:0] s1z, input logic [4:0] s1f,
                        input logic [1:0] s2z, input logic [4:0] s2f,
                        input logic [1:0] dz,  input logic [4:0] df,
                        input logic [127:0] wd,
                        input bit tt_also = 1'b0, input logic [2:0] ttv = 3'd0);
    logic [1:0] e_st;
    logic [127:0] e1, e2;
    bit bad;
    e1 = f_read(s1z, s1f);
    e2 = f_read(s2z, s2f);
    bad = (s1z == 3 && s1f[1]) || (s2z == 3 && s2f[1]) || (dz == 3 && df[1]);
    if (m_tt != exp_tt) e_st = 2'd1;
    else if (bad) begin e_st = 2'd2; m_tt = 3'd6; end
    else begin
      e_st = 2'd0;
      m_tt = 3'd0;
      if (dz != 0) model_write(dz, df, wd);
    end
    req_valid = 1; req_tt_exp = exp_tt;
    rs1_size = s1z; rs1_field = s1f; rs2_size = s2z; rs2_field = s2f;
    rd_size = dz; rd_field = df; wr_data = wd;
    tt_wr = tt_also; tt_wr_val = ttv;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0; tt_wr = 0;
    check({req, " resp_valid"}, resp_valid, 1'b1);
    check({req, " status"}, resp_status, e_st);
    if (e_st == 2'd0) begin
      check({req, " rs1_data"}, rs1_data, e1);
      check({req, " rs2_data"}, rs2_data, e2);
    end
    check_state(req);
    @(negedge clk);
    check({req, " R11 resp_valid drop"}, resp_valid, 1'b0);
  endtask

  task automatic set_tt(input logic [2:0] v);
    tt_wr = 1; tt_wr_val = v;
    @(posedge clk);
    @(negedge clk);
    tt_wr = 0;
    m_tt = v;
    check("R10 trap_type load", trap_type, v);
  endtask

  task automatic do_reset();
    rst = 1;
    repeat (3) @(negedge clk);
    check("R11 ready in reset", req_ready, 1'b0);
    check("R11 resp_valid in reset", resp_valid, 1'b0);
    m_tt = 0; m_fen = 0; m_live[0] = 0; m_live[1] = 0;
    check_state("R11 reset");
    rst = 0;
    @(negedge clk);
    check("R11 ready after reset", req_ready, 1'b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4177));
    @(negedge clk);
    do_reset();
    // R6: nothing live yet, every read returns zero
    access("R6", 3'd0, 2'd1, 5'd3, 2'd2, 5'd1, 2'd0, 5'd0, '0);
    // R9: read single 3 while first write to lower half targets it
    access("R9", 3'd0, 2'd1, 5'd3, 2'd0, 5'd0, 2'd1, 5'd3, 128'hA5A50001);
    // R1: double field 2 covers indices 2,3; single field 4 was cleared
    access("R1", 3'd0, 2'd2, 5'd2, 2'd1, 5'd4, 2'd0, 5'd0, '0);
    // R2: double field 1 lands at index 32
    access("R2", 3'd0, 2'd0, 5'd0, 2'd0, 5'd0, 2'd2, 5'd1, {64'h0, 32'hBBBB0002, 32'hAAAA0001});
    access("R2", 3'd0, 2'd3, 5'd1, 2'd2, 5'd1, 2'd0, 5'd0, '0);
    // R8: quad write to lower half (already live) keeps earlier word
    access("R8", 3'd0, 2'd1, 5'd3, 2'd0, 5'd0, 2'd3, 5'd4, {32'h4, 32'h3, 32'h2, 32'h1});
    access("R8", 3'd0, 2'd3, 5'd4, 2'd2, 5'd2, 2'd0, 5'd0, '0);
    // R3: illegal quad source, then illegal quad destination
    access("R3", 3'd0, 2'd3, 5'd2, 2'd0, 5'd0, 2'd0, 5'd0, '0);
    access("R3", 3'd6, 2'd0, 5'd0, 2'd0, 5'd0, 2'd3, 5'd6, {4{32'hDEAD0003}});
    // R4: mismatch, destination single 7 must stay unwritten
    access("R4", 3'd2, 2'd0, 5'd0, 2'd0, 5'd0, 2'd1, 5'd7, 128'hFEED0004);
    set_tt(3'd3);
    access("R5", 3'd3, 2'd1, 5'd7, 2'd3, 5'd4, 2'd0, 5'd0, '0);
    // R10: load request in the same cycle as an accepted access is ignored
    set_tt(3'd2);
    access("R10", 3'd2, 2'd0, 5'd0, 2'd0, 5'd0, 2'd0, 5'd0, '0, 1'b1, 3'd5);
    // R7: after reset, first write goes to upper; stale lower reads zero
    do_reset();
    access("R7", 3'd0, 2'd0, 5'd0, 2'd0, 5'd0, 2'd2, 5'd3, {64'h0, 32'h77, 32'h66});
    access("R7", 3'd0, 2'd1, 5'd3, 2'd2, 5'd3, 2'd0, 5'd0, '0);
    // random phase
    for (int n = 0; n < 600; n++) begin
      logic [2:0] et;
      et = ($urandom % 2) ? 3'd2 : 3'd3;
      if (n % 150 == 75) do_reset();
      if ($urandom % 5 != 0) set_tt(et);
      else set_tt(3'($urandom));
      access("R8 random", et, 2'($urandom), 5'($urandom), 2'($urandom), 5'($urandom),
             2'($urandom), 5'($urandom), {$urandom, $urandom, $urandom, $urandom});
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule